// File: doc/BRIEF.md
# Piecewise-Linear Sine Synthesizer

This block is a numerically controlled sine source. A 32-bit phase register adds a tuning word on every clock, so the output frequency is `f_clk * ftw / 2^32`. Each phase value goes to an amplitude converter that uses no full sine table. The converter first folds the phase into one quarter wave. It then finds which of 64 segments of unequal width contains the folded angle. It looks up that segment's base level and slope, and forms the level as base plus slope times the position inside the segment. The converter uses one small multiplier and one adder for this.

Segment edges sit on power-of-two phase points, measured as a distance from the quarter-wave peak. The segment can therefore be found by locating the leading one of that distance. The segments get narrower toward the peak, where the curve bends most. Each segment also stores a rounding-enable flag. When the flag is set, one extra count is added whenever the top discarded bit of the product is one. The result is an 11-bit two's-complement sample with a fixed four-cycle latency and a valid strobe.

The segment table is computed during elaboration from the size parameters. It is held in a registered read-only memory that can map onto block RAM.

Top module: `ddfs_pwl_sine`

## Requirements
- R1: The phase register starts at 0 after reset and adds `ftw` modulo 2^32 on every clock. The m-th valid sample after reset corresponds to phase `m*ftw mod 2^32`. With `ftw` = 0 every sample is 0, and a word of `2^32 - s` produces the phases of step `s` in reverse order.
- R2: While `rst` is high, `sample_vld` is 0 and `sample` is 0. After `rst` falls, `sample_vld` is 0 for the first three rising edges and 1 from the fourth edge on. It stays 1 until the next reset.
- R3: Whenever `sample_vld` is 0, `sample` is 0.
- R4: Every valid sample is within 4 LSB of `round(1023*sin(2*pi*p/2^32))`, where p is that sample's phase.
- R5: The sample for phase `p + 2^31` is exactly the two's-complement negation of the sample for phase p.
- R6: Phases 0 and 2^31 give 0. Phase 2^30 gives +1023 and phase 3*2^30 gives -1023. No sample ever has magnitude above 1023, so code -1024 never appears.
- R7: Within the first quarter turn (phase 0 to 2^30), the sample never decreases as the phase increases.
- R8: The error bound of R4 also holds within 2^24 of each quarter-turn point. These are the positions covered by the narrowest segments, near the peaks, and by the widest segments, near the zero crossings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ftw | input | 32 | Frequency tuning word added to the phase every clock |
| sample | output | 11 | Signed sine sample, full scale ±1023 |
| sample_vld | output | 1 | High when `sample` carries a converted phase |

## Verification
The bench builds the block with its default parameters: 32-bit phase, 11-bit output, and 8 groups of 8 segments. At these values a tuning step of 2^20 places exactly one sample in each of the narrowest segments. It also places 1024 samples in each quarter, so one full turn exercises every segment and every quadrant fold. The bench also uses a reversed step, an odd step that wraps the phase register, and a step of 2^30 + 2^12. The last one parks successive samples right beside all four quarter-turn points. Together these runs bring the exact symmetry, peak and monotonicity relations within reach, as well as the modular phase arithmetic.

// File: rtl/ddfs_pkg.sv
package ddfs_pkg;

  localparam real HALF_PI = 1.5707963267948966;

  // Width exponent of the segments in group g (groups beyond the last
  // leading-one group share the finest width).
  function automatic int grp_shift(input int g, input int grp_cnt,
                                   input int sub_bits, input int fold_w);
    int lim;
    lim = (g > grp_cnt - 2) ? grp_cnt - 2 : g;
    return fold_w - 1 - sub_bits - lim;
  endfunction

  // Level (scaled by full) of segment idx at one of its edges.
  // Distance y from the peak grows with the segment; near_peak picks the
  // edge closer to the peak (higher level).
  function automatic int seg_level(input int idx, input int grp_cnt,
                                   input int sub_bits, input int fold_w,
                                   input int full, input bit near_peak);
    int  g, s, w;
    real base, ypos, u, v;
    g = idx >> sub_bits;
    s = idx % (1 << sub_bits);
    w = grp_shift(g, grp_cnt, sub_bits, fold_w);
    base = (g > grp_cnt - 2) ? 0.0 : 2.0 ** (fold_w - 1 - g);
    ypos = base + real'(s + (near_peak ? 0 : 1)) * (2.0 ** w);
    u = ypos / (2.0 ** fold_w);
    v = real'(full) * $cos(HALF_PI * u);
    return $rtoi(v + 0.5);
  endfunction

endpackage

// File: rtl/ddfs_phase_acc.sv
module ddfs_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] ftw,
  output logic [PHASE_W-1:0] acc
);

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= acc + ftw;
  end

  // R2
  acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (acc == '0));

endmodule

// File: rtl/ddfs_fold.sv
module ddfs_fold
  import ddfs_pkg::*;
#(
  parameter int PHASE_W  = 32,
  parameter int NGRP     = 8,
  parameter int SUB_BITS = 3,
  parameter int OFF_W    = 7
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [PHASE_W-1:0]                   phase,
  output logic [$clog2(NGRP)+SUB_BITS-1:0]     idx,
  output logic [OFF_W-1:0]                     off,
  output logic                                 neg,
  output logic                                 vld
);

  localparam int FOLD_W = PHASE_W - 2;
  localparam int GRP_W  = $clog2(NGRP);
  localparam int IDX_W  = GRP_W + SUB_BITS;

  logic [FOLD_W-1:0] x, y;
  logic [IDX_W-1:0]  idx_c;
  logic [OFF_W-1:0]  off_c;
  int                g, w;

  always_comb begin
    // mirror the second half of each half-turn
    x = phase[PHASE_W-2] ? ~phase[FOLD_W-1:0] : phase[FOLD_W-1:0];
    y = ~x;  // distance to the peak
    g = NGRP - 1;
    for (int k = NGRP - 2; k >= 0; k--) begin
      if (y[FOLD_W-1-k]) g = k;
    end
    w     = grp_shift(g, NGRP, SUB_BITS, FOLD_W);
    idx_c = {GRP_W'(g), SUB_BITS'(y >> w)};
    // offset counted from the segment edge far from the peak equals x bits
    off_c = OFF_W'(x >> (w - OFF_W));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      off <= '0;
      neg <= 1'b0;
      vld <= 1'b0;
    end else begin
      idx <= idx_c;
      off <= off_c;
      neg <= phase[PHASE_W-1];
      vld <= 1'b1;
    end
  end

endmodule

// File: rtl/ddfs_seg_rom.sv
module ddfs_seg_rom
  import ddfs_pkg::*;
#(
  parameter int NGRP     = 8,
  parameter int SUB_BITS = 3,
  parameter int FOLD_W   = 30,
  parameter int START_W  = 11,
  parameter int SLOPE_W  = 11,
  parameter int FULL     = 2046
) (
  input  logic                             clk,
  input  logic [$clog2(NGRP)+SUB_BITS-1:0] idx,
  output logic [START_W-1:0]               start,
  output logic [SLOPE_W-1:0]               slope,
  output logic                             flag
);

  localparam int NSEG   = NGRP << SUB_BITS;
  localparam int WORD_W = 1 + SLOPE_W + START_W;

  logic [WORD_W-1:0] mem [NSEG];
  logic [WORD_W-1:0] rd;

  initial begin
    for (int i = 0; i < NSEG; i++) begin
      int lo_lvl;
      int hi_lvl;
      lo_lvl = seg_level(i, NGRP, SUB_BITS, FOLD_W, FULL, 1'b0);
      hi_lvl = seg_level(i, NGRP, SUB_BITS, FOLD_W, FULL, 1'b1);
      // slope taken from the rounded neighbour level keeps base+slope bounded
      mem[i] = {((hi_lvl - lo_lvl) >= 2), SLOPE_W'(hi_lvl - lo_lvl),
                START_W'(lo_lvl)};
    end
  end

  always_ff @(posedge clk) rd <= mem[idx];

  assign {flag, slope, start} = rd;

endmodule

// File: rtl/ddfs_interp.sv
module ddfs_interp #(
  parameter int AMP_W   = 11,
  parameter int SLOPE_W = 11,
  parameter int OFF_W   = 7,
  parameter int FULL    = 2046
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AMP_W-1:0] start,
  input  logic [SLOPE_W-1:0] slope,
  input  logic             flag,
  input  logic [OFF_W-1:0] off,
  input  logic             neg,
  input  logic             vld,
  output logic [AMP_W-1:0] sample,
  output logic             sample_vld
);

  localparam int PROD_W = SLOPE_W + OFF_W;
  localparam int MAG_W  = AMP_W - 1;

  logic [SLOPE_W:0]   prod_q;   // kept product bits plus the top dropped bit
  logic [AMP_W-1:0]   start_q, sum, pos, res;
  logic               flag_q, neg_q, vld_q, corr;
  logic [MAG_W-1:0]   mag;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q  <= '0;
      start_q <= '0;
      flag_q  <= 1'b0;
      neg_q   <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      prod_q  <= (SLOPE_W+1)'((PROD_W'(slope) * PROD_W'(off)) >> (OFF_W - 1));
      start_q <= start;
      flag_q  <= flag;
      neg_q   <= neg;
      vld_q   <= vld;
    end
  end

  always_comb begin
    corr = flag_q & prod_q[0];
    sum  = start_q + AMP_W'(prod_q[SLOPE_W:1]) + AMP_W'(corr);
    mag  = MAG_W'(sum >> 1);
    pos  = {1'b0, mag};
    res  = neg_q ? (~pos + 1'b1) : pos;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sample     <= '0;
      sample_vld <= 1'b0;
    end else begin
      sample     <= vld_q ? res : '0;
      sample_vld <= vld_q;
    end
  end

  // R6
  sum_range_chk: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> (32'(sum) <= FULL));

  // R6
  peak_bound_chk: assert property (@(posedge clk) disable iff (rst)
    sample_vld |-> (sample != {1'b1, {MAG_W{1'b0}}}));

  // R3
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !sample_vld |-> (sample == '0));

  // R2
  vld_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $past(sample_vld) |-> sample_vld);

endmodule

// File: rtl/ddfs_pwl_sine.sv
module ddfs_pwl_sine #(
  parameter int PHASE_W  = 32,
  parameter int AMP_W    = 11,
  parameter int NGRP     = 8,
  parameter int SUB_BITS = 3,
  parameter int OFF_W    = 7,
  parameter int SLOPE_W  = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] ftw,
  output logic [AMP_W-1:0]   sample,
  output logic               sample_vld
);

  localparam int FOLD_W = PHASE_W - 2;
  localparam int IDX_W  = $clog2(NGRP) + SUB_BITS;
  localparam int FULL   = 2 * ((1 << (AMP_W - 1)) - 1);

  logic [PHASE_W-1:0] acc;
  logic [IDX_W-1:0]   f_idx;
  logic [OFF_W-1:0]   f_off, s2_off;
  logic               f_neg, f_vld, s2_neg, s2_vld;
  logic [AMP_W-1:0]   r_start;
  logic [SLOPE_W-1:0] r_slope;
  logic               r_flag;

  ddfs_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst(rst), .ftw(ftw), .acc(acc)
  );

  ddfs_fold #(
    .PHASE_W(PHASE_W), .NGRP(NGRP), .SUB_BITS(SUB_BITS), .OFF_W(OFF_W)
  ) u_fold (
    .clk(clk), .rst(rst), .phase(acc),
    .idx(f_idx), .off(f_off), .neg(f_neg), .vld(f_vld)
  );

  ddfs_seg_rom #(
    .NGRP(NGRP), .SUB_BITS(SUB_BITS), .FOLD_W(FOLD_W),
    .START_W(AMP_W), .SLOPE_W(SLOPE_W), .FULL(FULL)
  ) u_rom (
    .clk(clk), .idx(f_idx),
    .start(r_start), .slope(r_slope), .flag(r_flag)
  );

  // align the side information with the registered table read
  always_ff @(posedge clk) begin
    if (rst) begin
      s2_off <= '0;
      s2_neg <= 1'b0;
      s2_vld <= 1'b0;
    end else begin
      s2_off <= f_off;
      s2_neg <= f_neg;
      s2_vld <= f_vld;
    end
  end

  ddfs_interp #(
    .AMP_W(AMP_W), .SLOPE_W(SLOPE_W), .OFF_W(OFF_W), .FULL(FULL)
  ) u_interp (
    .clk(clk), .rst(rst),
    .start(r_start), .slope(r_slope), .flag(r_flag),
    .off(s2_off), .neg(s2_neg), .vld(s2_vld),
    .sample(sample), .sample_vld(sample_vld)
  );

endmodule

// File: tb/tb_ddfs_pwl_sine.sv
`timescale 1ns/1ps
module tb_ddfs_pwl_sine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] ftw = '0;
  logic [10:0] sample;
  logic        sample_vld;

  int total = 0;
  int bad   = 0;
  int cur  [4096];
  int base [4096];

  always #2.5 clk = ~clk;

  ddfs_pwl_sine dut (
    .clk(clk), .rst(rst), .ftw(ftw),
    .sample(sample), .sample_vld(sample_vld)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ref_amp(input logic [31:0] p);
    real r;
    r = 1023.0 * $sin(2.0 * 3.14159265358979 * real'(p) / 4294967296.0);
    return $rtoi(r >= 0.0 ? r + 0.5 : r - 0.5);
  endfunction

  function automatic int sval();
    return int'($signed(sample));
  endfunction

  // reset, then gather n valid samples into cur[]
  task automatic run_case(input logic [31:0] f, input int n);
    rst = 1'b1;
    ftw = f;
    repeat (3) @(negedge clk);
    chk(!sample_vld, "R2 reset valid", int'(sample_vld), 0);
    chk(sample == '0, "R2 reset sample", sval(), 0);
    rst = 1'b0;
    for (int c = 1; c < n + 4; c++) begin
      @(negedge clk);
      if (c < 4) begin
        chk(!sample_vld, "R2 latency valid low", int'(sample_vld), 0);
        chk(sample == '0, "R3 idle sample", sval(), 0);
      end else begin
        if (c == 4 || c == n + 3)
          chk(sample_vld, "R2 valid high", int'(sample_vld), 1);
        cur[c-4] = sval();
      end
    end
  endtask

  task automatic accuracy(input logic [31:0] f, input int n, input string tag);
    for (int m = 0; m < n; m++) begin
      logic [31:0] p;
      int e, d;
      p = 32'(m) * f;
      e = ref_amp(p);
      d = cur[m] - e;
      chk(d <= 4 && d >= -4, tag, cur[m], e);
    end
  endtask

  initial begin
    #400000;
    bad++;
    total++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: zero tuning word keeps the phase at 0
    run_case(32'h0000_0000, 64);
    for (int m = 0; m < 64; m++) chk(cur[m] == 0, "R1 zero step", cur[m], 0);

    // one full turn, 1024 samples per quarter
    run_case(32'h0010_0000, 4096);
    for (int m = 0; m < 4096; m++) base[m] = cur[m];
    accuracy(32'h0010_0000, 4096, "R4 step 2^20");
    chk(cur[0] == 0,        "R6 phase 0",      cur[0], 0);
    chk(cur[1024] == 1023,  "R6 phase 2^30",   cur[1024], 1023);
    chk(cur[2048] == 0,     "R6 phase 2^31",   cur[2048], 0);
    chk(cur[3072] == -1023, "R6 phase 3*2^30", cur[3072], -1023);
    for (int m = 0; m < 2048; m++)
      chk(cur[m+2048] == -cur[m], "R5 half turn", cur[m+2048], -cur[m]);
    for (int m = 0; m < 1024; m++)
      chk(cur[m+1] >= cur[m], "R7 monotone", cur[m+1], cur[m]);

    // R1: reversed step must give the same phases backwards
    run_case(32'hFFF0_0000, 4096);
    for (int m = 0; m < 4096; m++)
      chk(cur[m] == base[(4096 - m) % 4096], "R1 reverse step",
          cur[m], base[(4096 - m) % 4096]);

    // odd step that wraps the phase register
    run_case(32'h0013_5795, 4096);
    accuracy(32'h0013_5795, 4096, "R4 odd step");
    for (int m = 0; m < 4096; m++)
      chk(cur[m] <= 1023 && cur[m] >= -1023, "R6 magnitude", cur[m], 1023);

    // samples beside each quarter-turn point
    run_case(32'h4000_1000, 4096);
    accuracy(32'h4000_1000, 4096, "R8 near quarter points");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule